// File: doc/BRIEF.md
# Reloadable Word and Transition Recognizer

This block is a bank of recognizer slots that sits in front of a trigger sequencer. Each cycle that carries a valid data sample, every slot tests the sample according to its own mode and raises a match flag for the sequencer. The flags are registered and appear one clock after the sample, together with a result strobe. Cycles without a valid sample produce no result.

A slot works in one of four modes. In word mode it compares the sample bit by bit against its reference under a care mask. In range mode an even slot uses its own reference as the lower bound and its odd neighbour's reference as the upper bound. In transition mode it watches one channel group for rising edges, falling edges or both, between the previous valid sample and the current one. A slot can also be switched off. References are loaded through a write port. A reload action from the sequencer can instead copy the live sample into any set of references.

Results are produced only while an acquisition is running. A small acquisition state machine has three states: `ACQ_IDLE`, `ACQ_FIRST` and `ACQ_RUN`. It moves from `ACQ_IDLE` to `ACQ_FIRST` on a start pulse. Once in `ACQ_FIRST`, the first valid sample moves it on to `ACQ_RUN`. A stop pulse returns it to `ACQ_IDLE` from either active state. A start pulse in any state re-enters `ACQ_FIRST`, and start takes priority over stop. The previous-sample register is cleared on start. The first valid sample of an acquisition therefore reports no transition.

Top module: `wtr_recognizer`

## Requirements
- R1: After reset, `match` and `match_vld` are 0, all references are 0 and the state is `ACQ_IDLE`.
- R2: A result (`match_vld`=1 one clock after the sample) is produced only for a cycle with `sample_valid`=1 while the acquisition is active (`ACQ_FIRST` or `ACQ_RUN`). In every other cycle, `match_vld` and all `match` bits are 0.
- R3: Mode code 1 (word): slot i's flag is 1 when `((sample ^ ref_i) & mask_i) == 0`. The fields of slot i are at `cfg_mode[2i+:2]`, `cfg_mask[16i+:16]`, `cfg_edge[2i+:2]` and `cfg_group[2i+:2]`.
- R4: Mode code 2 (range) on an even slot 2k with k < 4: the flag is 1 when `ref_2k & mask <= sample & mask <= ref_2k+1 & mask`, compared unsigned, using the mask of slot 2k. While such a pair is formed, the flag of slot 2k+1 is 0 whatever its own mode. Range mode on an odd slot or on slot 8 and above always gives 0.
- R5: When `reload_mask[i]`=1 in a valid sample cycle of an active acquisition, the sample is copied bit for bit into reference i. The flag for that same sample uses the old reference, and the next valid sample uses the new one.
- R6: A reload without `sample_valid` changes no reference. When a reload and a `ref_wr_en` write hit the same slot in one cycle, the reload value is kept. A write (slot `ref_wr_slot`) otherwise takes effect at the next edge in any state.
- R7: Mode code 3 (transition) watches channel group g = `cfg_group`, which covers sample bits [4g+3:4g]. With `cfg_edge[0]` set, the flag is 1 when any bit of the group went 0 to 1 since the previous valid sample. With `cfg_edge[1]` set, the flag is 1 when any bit went 1 to 0. With both set, either edge raises the flag, and with neither set the flag is always 0.
- R8: The first valid sample after a start pulse reports no transition on any slot. A start pulse during a running acquisition restarts this rule.
- R9: Mode code 0 (off) always gives a 0 flag.
- R10: A stop pulse returns the block to `ACQ_IDLE`, so later samples give no result. If start and stop are pulsed in the same cycle, start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acq_start | input | 1 | Acquisition start pulse |
| acq_stop | input | 1 | Acquisition stop pulse |
| sample_valid | input | 1 | Sample strobe |
| sample_data | input | 16 | Data sample |
| cfg_mode | input | 32 | Per-slot mode, 2 bits each |
| cfg_mask | input | 256 | Per-slot care mask, 16 bits each |
| cfg_edge | input | 32 | Per-slot edge select (bit0 rise, bit1 fall) |
| cfg_group | input | 32 | Per-slot channel group index |
| ref_wr_en | input | 1 | Reference write enable |
| ref_wr_slot | input | 4 | Reference write slot |
| ref_wr_data | input | 16 | Reference write value |
| reload_mask | input | 16 | Per-slot reload action |
| match | output | 16 | Per-slot match flags |
| match_vld | output | 1 | Result strobe |

## Verification
The hardest situations to reach are the timing corners of the reference registers. One is a reload whose own sample must still match the old reference. Another is a reload in a cycle without a sample, and a third is a reload colliding with a software write to the same slot. The stimulus creates each of them by placing the reload and the write in a chosen cycle. The following sample is chosen to equal exactly one of the competing values, so the flag shows which value was kept. The first-sample rule is reached in two ways: by restarting during a running acquisition with a sample whose groups differ from the previous one, and by pulsing start and stop together.

// File: rtl/wtr_pkg.sv
package wtr_pkg;

    typedef enum logic [1:0] {
        SLOT_OFF   = 2'd0,
        SLOT_WORD  = 2'd1,
        SLOT_RANGE = 2'd2,
        SLOT_TRANS = 2'd3
    } slot_mode_e;

    typedef enum logic [1:0] {
        ACQ_IDLE  = 2'd0,
        ACQ_FIRST = 2'd1,
        ACQ_RUN   = 2'd2
    } acq_state_e;

endpackage

// File: rtl/wtr_acq_fsm.sv
module wtr_acq_fsm
    import wtr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acq_start,
    input  logic acq_stop,
    input  logic sample_valid,
    output logic active,
    output logic first
);

    acq_state_e state_q;
    acq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACQ_IDLE: begin
                if (acq_start) state_d = ACQ_FIRST;
            end
            ACQ_FIRST: begin
                if (acq_start)         state_d = ACQ_FIRST;
                else if (acq_stop)     state_d = ACQ_IDLE;
                else if (sample_valid) state_d = ACQ_RUN;
            end
            ACQ_RUN: begin
                if (acq_start)     state_d = ACQ_FIRST;
                else if (acq_stop) state_d = ACQ_IDLE;
            end
            default: state_d = ACQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        active = 1'b0;
        first  = 1'b0;
        unique case (state_q)
            ACQ_IDLE:  begin active = 1'b0; first = 1'b0; end
            ACQ_FIRST: begin active = 1'b1; first = 1'b1; end
            ACQ_RUN:   begin active = 1'b1; first = 1'b0; end
            default:   begin active = 1'b0; first = 1'b0; end
        endcase
    end

endmodule

// File: rtl/wtr_ref_bank.sv
module wtr_ref_bank #(
    parameter int DW    = 16,
    parameter int NSLOT = 16,
    parameter int SW    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic [DW-1:0]       sample,
    input  logic [NSLOT-1:0]    reload,
    input  logic                wr_en,
    input  logic [SW-1:0]       wr_slot,
    input  logic [DW-1:0]       wr_data,
    output logic [NSLOT*DW-1:0] refs
);

    for (genvar i = 0; i < NSLOT; i++) begin : g_ref
        logic [DW-1:0] ref_q;
        logic          do_reload;
        logic          do_write;

        assign do_reload = take && reload[i];
        assign do_write  = wr_en && (int'(wr_slot) == i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         ref_q <= '0;
            else if (do_reload) ref_q <= sample;
            else if (do_write)  ref_q <= wr_data;
        end

        assign refs[i*DW +: DW] = ref_q;
    end

endmodule

// File: rtl/wtr_slot_eval.sv
module wtr_slot_eval
    import wtr_pkg::*;
#(
    parameter int DW       = 16,
    parameter int GW       = 4,
    parameter int NGROUP   = 4,
    parameter int GSW      = 2,
    parameter bit RANGE_OK = 1'b0
) (
    input  logic [DW-1:0]  sample,
    input  logic [DW-1:0]  prev,
    input  logic [DW-1:0]  ref_own,
    input  logic [DW-1:0]  ref_upper,
    input  logic [1:0]     mode,
    input  logic [DW-1:0]  mask,
    input  logic [1:0]     edge_sel,
    input  logic [GSW-1:0] group,
    input  logic           trans_ok,
    input  logic           silenced,
    output logic           hit
);

    logic [DW-1:0] s_m, lo_m, hi_m;
    logic [GW-1:0] cur_g, prv_g;
    logic          rise, fall, word_hit, range_hit, trans_hit;
    int            gi;

    assign s_m  = sample & mask;
    assign lo_m = ref_own & mask;
    assign hi_m = ref_upper & mask;

    always_comb begin
        gi    = int'(group);
        cur_g = '0;
        prv_g = '0;
        if (gi < NGROUP) begin
            cur_g = sample[gi*GW +: GW];
            prv_g = prev[gi*GW +: GW];
        end
    end

    assign rise      = |(cur_g & ~prv_g);
    assign fall      = |(~cur_g & prv_g);
    assign word_hit  = ((sample ^ ref_own) & mask) == '0;
    assign range_hit = RANGE_OK && (s_m >= lo_m) && (s_m <= hi_m);
    assign trans_hit = trans_ok && ((edge_sel[0] && rise) || (edge_sel[1] && fall));

    always_comb begin
        hit = 1'b0;
        unique case (slot_mode_e'(mode))
            SLOT_OFF:   hit = 1'b0;
            SLOT_WORD:  hit = word_hit;
            SLOT_RANGE: hit = range_hit;
            SLOT_TRANS: hit = trans_hit;
            default:    hit = 1'b0;
        endcase
        if (silenced) hit = 1'b0;
    end

endmodule

// File: rtl/wtr_recognizer.sv
module wtr_recognizer
    import wtr_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int GROUP_W     = 4,
    parameter int SLOTS       = 16,
    parameter int RANGE_PAIRS = 4,
    localparam int NGROUP     = DATA_W / GROUP_W,
    localparam int GSW        = (NGROUP > 1) ? $clog2(NGROUP) : 1,
    localparam int SW         = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acq_start,
    input  logic                   acq_stop,
    input  logic                   sample_valid,
    input  logic [DATA_W-1:0]      sample_data,
    input  logic [SLOTS*2-1:0]     cfg_mode,
    input  logic [SLOTS*DATA_W-1:0] cfg_mask,
    input  logic [SLOTS*2-1:0]     cfg_edge,
    input  logic [SLOTS*GSW-1:0]   cfg_group,
    input  logic                   ref_wr_en,
    input  logic [SW-1:0]          ref_wr_slot,
    input  logic [DATA_W-1:0]      ref_wr_data,
    input  logic [SLOTS-1:0]       reload_mask,
    output logic [SLOTS-1:0]       match,
    output logic                   match_vld
);

    logic                    active, first, take;
    logic [DATA_W-1:0]       prev_q;
    logic [SLOTS*DATA_W-1:0] refs;
    logic [SLOTS-1:0]        hits;

    wtr_acq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .acq_start    (acq_start),
        .acq_stop     (acq_stop),
        .sample_valid (sample_valid),
        .active       (active),
        .first        (first)
    );

    assign take = sample_valid && active;

    wtr_ref_bank #(.DW(DATA_W), .NSLOT(SLOTS), .SW(SW)) u_refs (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .sample  (sample_data),
        .reload  (reload_mask),
        .wr_en   (ref_wr_en),
        .wr_slot (ref_wr_slot),
        .wr_data (ref_wr_data),
        .refs    (refs)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         prev_q <= '0;
        else if (acq_start) prev_q <= '0;
        else if (take)      prev_q <= sample_data;
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        localparam bit CAN_RANGE = ((i % 2) == 0) && ((i / 2) < RANGE_PAIRS) && (i + 1 < SLOTS);
        localparam int UP        = (i + 1) % SLOTS;
        logic silenced;

        if ((i % 2) == 1 && ((i - 1) / 2) < RANGE_PAIRS) begin : g_partner
            assign silenced = (cfg_mode[(i-1)*2 +: 2] == 2'(SLOT_RANGE));
        end else begin : g_alone
            assign silenced = 1'b0;
        end

        wtr_slot_eval #(
            .DW(DATA_W), .GW(GROUP_W), .NGROUP(NGROUP), .GSW(GSW), .RANGE_OK(CAN_RANGE)
        ) u_eval (
            .sample    (sample_data),
            .prev      (prev_q),
            .ref_own   (refs[i*DATA_W +: DATA_W]),
            .ref_upper (refs[UP*DATA_W +: DATA_W]),
            .mode      (cfg_mode[i*2 +: 2]),
            .mask      (cfg_mask[i*DATA_W +: DATA_W]),
            .edge_sel  (cfg_edge[i*2 +: 2]),
            .group     (cfg_group[i*GSW +: GSW]),
            .trans_ok  (!first),
            .silenced  (silenced),
            .hit       (hits[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match     <= '0;
            match_vld <= 1'b0;
        end else if (take) begin
            match     <= hits;
            match_vld <= 1'b1;
        end else begin
            match     <= '0;
            match_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/wtr_recognizer_chk.sv
module wtr_recognizer_chk #(
    parameter int SLOTS       = 16,
    parameter int RANGE_PAIRS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acq_start,
    input logic               acq_stop,
    input logic               sample_valid,
    input logic [SLOTS*2-1:0] cfg_mode,
    input logic [SLOTS-1:0]   match,
    input logic               match_vld
);

    logic act, fst, smp_act_q, smp_fst_q;
    logic [SLOTS*2-1:0] mode_q;
    logic [SLOTS-1:0] off_m, trans_m, odd_m;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act <= 1'b0; fst <= 1'b0;
            smp_act_q <= 1'b0; smp_fst_q <= 1'b0;
            mode_q <= '0;
        end else begin
            smp_act_q <= act;
            smp_fst_q <= fst;
            mode_q    <= cfg_mode;
            if (acq_start) begin
                act <= 1'b1; fst <= 1'b1;
            end else if (acq_stop) begin
                act <= 1'b0; fst <= 1'b0;
            end else if (sample_valid && act) begin
                fst <= 1'b0;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            off_m[i]   = (mode_q[i*2 +: 2] == 2'd0);
            trans_m[i] = (mode_q[i*2 +: 2] == 2'd3);
            odd_m[i]   = 1'b0;
            if ((i % 2) == 1 && ((i - 1) / 2) < RANGE_PAIRS)
                odd_m[i] = (mode_q[(i-1)*2 +: 2] == 2'd2);
        end
    end

    AST_RESULT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        match_vld |-> $past(sample_valid)); // R2

    AST_RESULT_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        match_vld |-> smp_act_q); // R10

    AST_QUIET_WITHOUT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !match_vld |-> (match == '0)); // R2

    AST_OFF_SLOT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        match_vld |-> ((match & off_m) == '0)); // R9

    AST_UPPER_SLOT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        match_vld |-> ((match & odd_m) == '0)); // R4

    AST_FIRST_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vld && smp_fst_q) |-> ((match & trans_m) == '0)); // R8

endmodule

bind wtr_recognizer wtr_recognizer_chk #(.SLOTS(SLOTS), .RANGE_PAIRS(RANGE_PAIRS)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .acq_start    (acq_start),
    .acq_stop     (acq_stop),
    .sample_valid (sample_valid),
    .cfg_mode     (cfg_mode),
    .match        (match),
    .match_vld    (match_vld)
);

// File: tb/wtr_recognizer_tb_top.sv
`timescale 1ns/1ps
module wtr_recognizer_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acq_start = 0, acq_stop = 0, sample_valid = 0;
    logic [15:0] sample_data = '0;
    logic [31:0] cfg_mode = '0;
    logic [255:0] cfg_mask = '0;
    logic [31:0] cfg_edge = '0;
    logic [31:0] cfg_group = '0;
    logic ref_wr_en = 0;
    logic [3:0] ref_wr_slot = '0;
    logic [15:0] ref_wr_data = '0;
    logic [15:0] reload_mask = '0;
    logic [15:0] match;
    logic match_vld;

    always #4 clk = ~clk;

    wtr_recognizer dut_i (
        .clk(clk), .rst_n(rst_n), .acq_start(acq_start), .acq_stop(acq_stop),
        .sample_valid(sample_valid), .sample_data(sample_data),
        .cfg_mode(cfg_mode), .cfg_mask(cfg_mask), .cfg_edge(cfg_edge), .cfg_group(cfg_group),
        .ref_wr_en(ref_wr_en), .ref_wr_slot(ref_wr_slot), .ref_wr_data(ref_wr_data),
        .reload_mask(reload_mask), .match(match), .match_vld(match_vld)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] exp_q[$];
    string tag_q[$];

    logic [15:0] mref [16];
    logic [15:0] mprev = '0;
    logic mact = 0, mfirst = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_eval(input logic [15:0] s);
        logic [15:0] r;
        r = '0;
        for (int i = 0; i < 16; i++) begin
            logic [1:0] md;
            logic [15:0] mk;
            logic [3:0] cg, pg;
            int g;
            md = cfg_mode[i*2 +: 2];
            mk = cfg_mask[i*16 +: 16];
            g  = int'(cfg_group[i*2 +: 2]);
            cg = s[g*4 +: 4];
            pg = mprev[g*4 +: 4];
            case (md)
                2'd1: r[i] = ((s ^ mref[i]) & mk) == 16'h0;
                2'd2: if (i % 2 == 0 && i < 8)
                          r[i] = ((s & mk) >= (mref[i] & mk)) && ((s & mk) <= (mref[i+1] & mk));
                2'd3: if (!mfirst)
                          r[i] = (cfg_edge[i*2] && |(cg & ~pg)) || (cfg_edge[i*2+1] && |(~cg & pg));
                default: r[i] = 1'b0;
            endcase
            if (i % 2 == 1 && i < 8 && cfg_mode[(i-1)*2 +: 2] == 2'd2) r[i] = 1'b0;
        end
        return r;
    endfunction

    task automatic cyc(input logic v, input logic [15:0] d, input logic [15:0] rl,
                       input logic st, input logic sp, input logic we,
                       input logic [3:0] ws, input logic [15:0] wd, input string tag);
        @(negedge clk);
        sample_valid = v; sample_data = d; reload_mask = rl;
        acq_start = st; acq_stop = sp;
        ref_wr_en = we; ref_wr_slot = ws; ref_wr_data = wd;
        if (v && mact) begin
            exp_q.push_back(model_eval(d));
            tag_q.push_back(tag);
        end
        if (we) mref[ws] = wd;
        if (v && mact) begin
            for (int i = 0; i < 16; i++) if (rl[i]) mref[i] = d;
        end
        if (st) begin
            mact = 1; mfirst = 1; mprev = '0;
        end else begin
            if (v && mact) begin mprev = d; mfirst = 0; end
            if (sp) begin mact = 0; mfirst = 0; end
        end
        @(posedge clk);
        #1;
    endtask

    task automatic smp(input logic [15:0] d, input string tag);
        cyc(1, d, 16'h0, 0, 0, 0, 4'h0, 16'h0, tag);
    endtask

    task automatic idle1();
        cyc(0, 16'h0, 16'h0, 0, 0, 0, 4'h0, 16'h0, "idle");
    endtask

    task automatic wr_ref(input logic [3:0] s, input logic [15:0] v);
        cyc(0, 16'h0, 16'h0, 0, 0, 1, s, v, "write");
    endtask

    task automatic set_slot(input int i, input logic [1:0] md, input logic [15:0] mk,
                            input logic [1:0] ed, input logic [1:0] gr);
        cfg_mode[i*2 +: 2] = md;
        cfg_mask[i*16 +: 16] = mk;
        cfg_edge[i*2 +: 2] = ed;
        cfg_group[i*2 +: 2] = gr;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (match_vld) begin
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected result", 32'(match_vld), 32'd0);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, 32'(match), 32'(e));
                end
            end else if (match !== 16'h0) begin
                chk("R2 flags without result", 32'(match), 32'd0);
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        chk("watchdog expired", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) mref[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 match after reset", 32'(match), 32'd0);
        chk("R1 match_vld after reset", 32'(match_vld), 32'd0);
        rst_n = 1'b1;

        // R1: references reset to 0: slot 0 word full mask matches 0 at first sample
        set_slot(0, 2'd1, 16'hFFFF, 2'b00, 2'd0);
        // R2: samples while idle give nothing
        smp(16'h0000, "R2 idle");
        smp(16'h1234, "R2 idle");
        idle1();
        chk("R2 idle ignored", 32'(match_vld), 32'd0);
        cyc(0, 16'h0, 16'h0, 1, 0, 0, 4'h0, 16'h0, "start");
        smp(16'h0000, "R1 reset reference");
        smp(16'hFFFF, "R1 reset reference no match");
        cyc(0, 16'h0, 16'h0, 0, 1, 0, 4'h0, 16'h0, "stop");

        // configuration
        set_slot(1, 2'd1, 16'h00FF, 2'b00, 2'd0);
        set_slot(2, 2'd2, 16'hFFFF, 2'b00, 2'd0);
        set_slot(3, 2'd1, 16'hFFFF, 2'b00, 2'd0);
        set_slot(4, 2'd3, 16'h0000, 2'b01, 2'd1);
        set_slot(5, 2'd3, 16'h0000, 2'b10, 2'd0);
        set_slot(6, 2'd3, 16'h0000, 2'b11, 2'd2);
        set_slot(7, 2'd3, 16'h0000, 2'b00, 2'd3);
        set_slot(8, 2'd2, 16'hFFFF, 2'b00, 2'd0);
        set_slot(9, 2'd0, 16'hFFFF, 2'b00, 2'd0);
        set_slot(10, 2'd1, 16'hFFFF, 2'b00, 2'd0);
        set_slot(11, 2'd1, 16'h0000, 2'b00, 2'd0);
        wr_ref(4'd0, 16'h1234);
        wr_ref(4'd1, 16'hAB34);
        wr_ref(4'd2, 16'h0100);
        wr_ref(4'd3, 16'h0200);
        wr_ref(4'd8, 16'h0000);
        wr_ref(4'd9, 16'h1234);
        wr_ref(4'd10, 16'h0150);

        cyc(0, 16'h0, 16'h0, 1, 0, 0, 4'h0, 16'h0, "start");
        smp(16'hFFFF, "R8 first sample no transition");
        smp(16'h1234, "R3 word exact");
        smp(16'h5634, "R3 word masked");
        smp(16'h00FF, "R4 range below lower bound");
        smp(16'h0100, "R4 range at lower bound");
        smp(16'h0200, "R4 range at upper bound");
        smp(16'h0201, "R4 range above upper bound");
        smp(16'h0150, "R4 range inside, R9 off slot");
        smp(16'h00F0, "R7 rise group1");
        smp(16'h000F, "R7 fall group1 rise group0");
        smp(16'h0F00, "R7 fall group0 both group2");
        smp(16'h0000, "R7 both group2 fall");
        smp(16'hF000, "R7 no edge select group3");

        // R5 reload
        cyc(1, 16'h4321, 16'h0400, 0, 0, 0, 4'h0, 16'h0, "R5 reload sample uses old ref");
        smp(16'h4321, "R5 new ref after reload");
        // R6 reload without valid is ignored
        cyc(0, 16'hAAAA, 16'h0400, 0, 0, 0, 4'h0, 16'h0, "R6 reload no sample");
        smp(16'hAAAA, "R6 reload without sample ignored");
        smp(16'h4321, "R6 ref kept");
        // R6 reload beats write
        cyc(1, 16'h5555, 16'h0400, 0, 0, 1, 4'd10, 16'h7777, "R6 reload and write");
        smp(16'h5555, "R6 reload wins");
        smp(16'h7777, "R6 write lost");
        // R4 range on upper slot of pair turned to range is silent too
        set_slot(3, 2'd2, 16'hFFFF, 2'b00, 2'd0);
        smp(16'h0180, "R4 odd slot range silent");

        // R8 restart mid-run
        cyc(0, 16'h0, 16'h0, 1, 0, 0, 4'h0, 16'h0, "restart");
        smp(16'hFFFF, "R8 restart first sample no transition");
        smp(16'h0000, "R7 falls after restart");

        // R10 stop then ignored
        cyc(0, 16'h0, 16'h0, 0, 1, 0, 4'h0, 16'h0, "stop");
        smp(16'h1234, "R10 after stop");
        smp(16'h0F0F, "R10 after stop");
        idle1();
        chk("R10 stopped no result", 32'(match_vld), 32'd0);
        // R10 start and stop together, with sample in same cycle (ignored: idle)
        cyc(1, 16'h1234, 16'h0, 1, 1, 0, 4'h0, 16'h0, "R10 start wins");
        smp(16'hFFFF, "R10 active after start+stop, R8 no transition");
        smp(16'h1234, "R10 running");
        // R9 switch everything off
        for (int i = 0; i < 16; i++) set_slot(i, 2'd0, 16'h0000, 2'b11, 2'd0);
        smp(16'h0000, "R9 all off");
        idle1();
        idle1();
        chk("R3 all results delivered", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule